// File: doc/BRIEF.md
# Converter Protection Supervisor

This block is the supervisory sequencer of a fixed-frequency switching-converter controller. It receives already-digitised condition flags (supply level comparators, die over-temperature, current-limit and overcurrent comparators, the maximum-duty terminator, the light-load skip comparators and the two-sided external shutdown input). From these it decides whether the power switch may be driven. It also decides whether the peak-current soft-start ramp is in progress and whether the external shutdown pin's bias current must be doubled.

Internally a registered state machine moves between idle, soft-start, regulating, skip, latched shutdown and an autorecovery pause. Beside it sit an overload timer fed only by the current-limit flag, a shared phase counter that times both soft-start and the recovery pause, and four persistence qualifiers. The qualifiers hold back undervoltage, supply overvoltage and the high and low shutdown-pin events until each has lasted its own number of clock ticks. All durations are parameters in clock ticks. A static input picks whether a protection event is latched or recovers by itself.

Top module: `cvt_supervisor`

## Requirements
- R1: While `rst` is high, and afterwards until `vcc_on` is seen, `drv_en`, `ss_active` and `latch_dbl` are all 0.
- R2: In the idle state, `vcc_on`=1 with `tsd`=0 and `vcc_reset_lo`=0 enters soft-start at the next edge. Soft-start then lasts exactly SS_TICKS cycles with `drv_en`=1 and `ss_active`=`latch_dbl`=1, and is followed by regulation with `drv_en`=1 and `ss_active`=0.
- R3: In soft-start or regulation, `ilim_hit` high for FAULT_TICKS consecutive sampled cycles triggers protection. `drv_en` is still 1 after the FAULT_TICKS-th edge and is 0 after the next edge.
- R4: A single cycle with `ilim_hit`=0 restarts the overload count from zero, so a full FAULT_TICKS run is needed again.
- R5: A cycle with `ilim_hit`=1 and `maxduty_end`=1 does not start the overload count while it is at zero. Once the count is running, `maxduty_end` does not hold it back.
- R6: `cs_stop`=1 while driving triggers protection, and `drv_en` is 0 after the next edge.
- R7: With `cfg_autorec`=0, protection is a latched shutdown. `drv_en` stays 0 regardless of `vcc_on`, `tsd` or `vcc_off` until `vcc_reset_lo` is seen.
- R8: With `cfg_autorec`=1, an overload or overcurrent fault holds `drv_en` at 0 for AR_TICKS cycles and then returns to idle for one cycle. With `vcc_on` high, soft-start begins on the following edge.
- R9: `vcc_ovp` or `latch_hi` high for BLANK_TICKS or LHI_TICKS consecutive cycles respectively, while in soft-start, regulation or skip, latches the block off after one further edge. This holds in both options. A shorter pulse has no effect.
- R10: `latch_lo` is not counted during soft-start. In regulation or skip, LLO_TICKS consecutive cycles latch the block off after one further edge, and a shorter pulse has no effect.
- R11: In regulation, `skip_in`=1 enters skip (`drv_en`=0, `ss_active`=0) at the next edge. Skip is held until `skip_out`=1, which resumes regulation at the next edge.
- R12: `vcc_off` persisting BLANK_TICKS cycles, or `tsd`=1 for one cycle, returns the block to idle and clears the overload count. Idle is not a latched state: with `tsd` low and `vcc_on` high, soft-start restarts.
- R13: `vcc_reset_lo`=1 forces idle from any state, including latched shutdown, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_autorec | input | 1 | Static option: 1 = autorecovery, 0 = latched protection |
| vcc_on | input | 1 | Supply above the turn-on level |
| vcc_off | input | 1 | Supply below the turn-off level |
| vcc_reset_lo | input | 1 | Supply below the logic reset level |
| vcc_ovp | input | 1 | Supply above the overvoltage level |
| tsd | input | 1 | Die over-temperature |
| ilim_hit | input | 1 | Peak-current setpoint clamped at its maximum |
| cs_stop | input | 1 | Current sense reached the immediate-stop level |
| maxduty_end | input | 1 | Present drive pulse was ended by the duty-cycle limit |
| skip_in | input | 1 | Feedback fell below the skip entry level |
| skip_out | input | 1 | Feedback rose above the skip exit level |
| latch_hi | input | 1 | Shutdown pin above its high threshold |
| latch_lo | input | 1 | Shutdown pin below its low threshold |
| drv_en | output | 1 | Switching permitted |
| ss_active | output | 1 | Soft-start ramp in progress |
| latch_dbl | output | 1 | Double the shutdown pin bias current |

## Verification
The overload path is driven with a continuous current-limit run, with a run broken by one quiet cycle, and with runs whose first cycles are ended by the duty limit. Together these separate a count that restarts from one that accumulates, and a duty exemption that only blocks starting from one that pauses the count. Each persistence qualifier receives a pulse one cycle short of its window and then an exact window, which pins the boundary cycle. The low shutdown input is held from power-up so that a qualifier counting during soft-start would trip early. Latched and autorecovery options run the same fault, and the pause boundary is checked on both sides.

// File: rtl/cvt_sup_pkg.sv
package cvt_sup_pkg;

    typedef enum logic [2:0] {
        ST_STOP     = 3'd0,
        ST_SOFT     = 3'd1,
        ST_RUN      = 3'd2,
        ST_SKIP     = 3'd3,
        ST_LATCH    = 3'd4,
        ST_AUTOWAIT = 3'd5
    } sup_state_e;

    typedef struct packed {
        logic drv_en;
        logic ss_active;
        logic latch_dbl;
    } sup_ctl_t;

    // Qualifier slots
    localparam int unsigned QF_UV    = 0;
    localparam int unsigned QF_OVP   = 1;
    localparam int unsigned QF_LHI   = 2;
    localparam int unsigned QF_LLO   = 3;
    localparam int unsigned QF_COUNT = 4;

    function automatic logic is_switching(sup_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

    function automatic logic is_powered(sup_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN) || (s == ST_SKIP);
    endfunction

    function automatic logic is_settled(sup_state_e s);
        return (s == ST_RUN) || (s == ST_SKIP);
    endfunction

    function automatic int unsigned qual_len(int unsigned idx, int unsigned blank,
                                             int unsigned lhi, int unsigned llo);
        case (idx)
            QF_UV, QF_OVP: return blank;
            QF_LHI:        return lhi;
            default:       return llo;
        endcase
    endfunction

    // Phase in which each qualifier is allowed to accumulate
    function automatic logic qual_enable(int unsigned idx, sup_state_e s);
        case (idx)
            QF_UV:         return is_powered(s) || (s == ST_AUTOWAIT);
            QF_OVP, QF_LHI: return is_powered(s);
            default:       return is_settled(s);
        endcase
    endfunction

    function automatic sup_ctl_t decode_ctl(sup_state_e s);
        sup_ctl_t c;
        c.drv_en    = is_switching(s);
        c.ss_active = (s == ST_SOFT);
        c.latch_dbl = (s == ST_SOFT);
        return c;
    endfunction

endpackage

// File: rtl/cvt_persist.sv
module cvt_persist #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic hit
);
    localparam int unsigned W = $clog2(LEN + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || !din) begin
            cnt <= '0;
        end else if (cnt != W'(LEN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == W'(LEN));

endmodule

// File: rtl/cvt_fault_timer.sv
module cvt_fault_timer #(
    parameter int unsigned LEN = 128,
    localparam int unsigned W  = $clog2(LEN + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         ilim,
    input  logic         maxduty,
    output logic [W-1:0] count_o,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm || !ilim) begin
            cnt <= '0;
        end else if ((cnt == '0) && maxduty) begin
            cnt <= '0;
        end else if (cnt != W'(LEN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign count_o = cnt;
    assign expired = (cnt == W'(LEN));

endmodule

// File: rtl/cvt_sup_fsm.sv
module cvt_sup_fsm
    import cvt_sup_pkg::*;
#(
    parameter int unsigned SS_TICKS = 4000,
    parameter int unsigned AR_TICKS = 1000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_autorec,
    input  logic                vcc_on,
    input  logic                vcc_reset_lo,
    input  logic                tsd,
    input  logic                cs_stop,
    input  logic                skip_in,
    input  logic                skip_out,
    input  logic                fault_exp,
    input  logic [QF_COUNT-1:0] qual_hit,
    output sup_state_e          state_o,
    output sup_ctl_t            ctl_o
);
    localparam int unsigned PMAX = (SS_TICKS > AR_TICKS) ? SS_TICKS : AR_TICKS;
    localparam int unsigned PW   = $clog2(PMAX + 1);

    sup_state_e    state, nxt;
    logic [PW-1:0] ph_cnt;
    logic          go_down, go_latch, go_fault;

    assign go_down  = tsd || qual_hit[QF_UV];
    assign go_latch = qual_hit[QF_OVP] || qual_hit[QF_LHI] || qual_hit[QF_LLO];
    assign go_fault = is_switching(state) && (fault_exp || cs_stop);

    always_comb begin
        nxt = state;
        if (vcc_reset_lo) begin
            nxt = ST_STOP;
        end else begin
            case (state)
                ST_STOP: begin
                    if (vcc_on && !tsd) nxt = ST_SOFT;
                end
                ST_LATCH: begin
                    nxt = ST_LATCH;
                end
                ST_AUTOWAIT: begin
                    if (go_down || (ph_cnt == PW'(AR_TICKS - 1))) nxt = ST_STOP;
                end
                default: begin
                    if (go_down) begin
                        nxt = ST_STOP;
                    end else if (go_latch) begin
                        nxt = ST_LATCH;
                    end else if (go_fault) begin
                        nxt = cfg_autorec ? ST_AUTOWAIT : ST_LATCH;
                    end else begin
                        case (state)
                            ST_SOFT: if (ph_cnt == PW'(SS_TICKS - 1)) nxt = ST_RUN;
                            ST_RUN:  if (skip_in) nxt = ST_SKIP;
                            ST_SKIP: if (skip_out) nxt = ST_RUN;
                            default: nxt = ST_STOP;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_STOP;
            ph_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                ph_cnt <= '0;
            end else if (ph_cnt != PW'(PMAX)) begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign state_o = state;
    assign ctl_o   = decode_ctl(state);

endmodule

// File: rtl/cvt_supervisor.sv
module cvt_supervisor
    import cvt_sup_pkg::*;
#(
    parameter int unsigned SS_TICKS    = 4000,
    parameter int unsigned FAULT_TICKS = 128000,
    parameter int unsigned BLANK_TICKS = 10000,
    parameter int unsigned LHI_TICKS   = 50000,
    parameter int unsigned LLO_TICKS   = 350000,
    parameter int unsigned AR_TICKS    = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_autorec,
    input  logic vcc_on,
    input  logic vcc_off,
    input  logic vcc_reset_lo,
    input  logic vcc_ovp,
    input  logic tsd,
    input  logic ilim_hit,
    input  logic cs_stop,
    input  logic maxduty_end,
    input  logic skip_in,
    input  logic skip_out,
    input  logic latch_hi,
    input  logic latch_lo,
    output logic drv_en,
    output logic ss_active,
    output logic latch_dbl
);
    localparam int unsigned FW = $clog2(FAULT_TICKS + 1);

    sup_state_e          cur_state;
    sup_ctl_t            ctl;
    logic [QF_COUNT-1:0] q_in, q_en, q_hit;
    logic [FW-1:0]       ft_cnt;
    logic                ft_exp;

    assign q_in[QF_UV]  = vcc_off;
    assign q_in[QF_OVP] = vcc_ovp;
    assign q_in[QF_LHI] = latch_hi;
    assign q_in[QF_LLO] = latch_lo;

    for (genvar g = 0; g < QF_COUNT; g++) begin : g_qual
        assign q_en[g] = qual_enable(g, cur_state);
        cvt_persist #(
            .LEN(qual_len(g, BLANK_TICKS, LHI_TICKS, LLO_TICKS))
        ) u_qual (
            .clk(clk),
            .rst(rst),
            .en (q_en[g]),
            .din(q_in[g]),
            .hit(q_hit[g])
        );
    end

    cvt_fault_timer #(
        .LEN(FAULT_TICKS)
    ) u_fault (
        .clk    (clk),
        .rst    (rst),
        .arm    (is_switching(cur_state)),
        .ilim   (ilim_hit),
        .maxduty(maxduty_end),
        .count_o(ft_cnt),
        .expired(ft_exp)
    );

    cvt_sup_fsm #(
        .SS_TICKS(SS_TICKS),
        .AR_TICKS(AR_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg_autorec (cfg_autorec),
        .vcc_on      (vcc_on),
        .vcc_reset_lo(vcc_reset_lo),
        .tsd         (tsd),
        .cs_stop     (cs_stop),
        .skip_in     (skip_in),
        .skip_out    (skip_out),
        .fault_exp   (ft_exp),
        .qual_hit    (q_hit),
        .state_o     (cur_state),
        .ctl_o       (ctl)
    );

    assign drv_en    = ctl.drv_en;
    assign ss_active = ctl.ss_active;
    assign latch_dbl = ctl.latch_dbl;

endmodule

// File: rtl/cvt_supervisor_chk.sv
module cvt_supervisor_chk
    import cvt_sup_pkg::*;
#(
    parameter int unsigned SS_TICKS    = 4000,
    parameter int unsigned FAULT_TICKS = 128000,
    localparam int unsigned FW = $clog2(FAULT_TICKS + 1),
    localparam int unsigned SW = $clog2(SS_TICKS + 2)
) (
    input logic          clk,
    input logic          rst,
    input logic          vcc_reset_lo,
    input logic          cs_stop,
    input logic          ilim_hit,
    input logic          maxduty_end,
    input logic          skip_out,
    input logic          drv_en,
    input logic          ss_active,
    input sup_state_e    cur_state,
    input logic [FW-1:0] ft_cnt
);
    logic [SW-1:0] ss_len;

    always_ff @(posedge clk) begin
        if (rst || !ss_active) begin
            ss_len <= '0;
        end else if (ss_len != SW'(SS_TICKS + 1)) begin
            ss_len <= ss_len + 1'b1;
        end
    end

    // R2: a completed soft-start spans exactly SS_TICKS cycles
    assert_ss_length_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(ss_active) && drv_en) |-> (ss_len == SW'(SS_TICKS)));

    // R5: duty-limited cycle leaves an idle overload count idle
    assert_maxduty_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ilim_hit && maxduty_end && (ft_cnt == '0)) |=> (ft_cnt == '0));

    // R6: immediate overcurrent removes drive on the next cycle
    assert_cs_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (drv_en && cs_stop) |=> !drv_en);

    // R7: latched shutdown only leaves on the reset level
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((cur_state == ST_LATCH) && !vcc_reset_lo) |=> (cur_state == ST_LATCH));

    // R11: skip keeps the switch off until skip exit
    assert_skip_off_R11: assert property (@(posedge clk) disable iff (rst)
        ((cur_state == ST_SKIP) && !skip_out) |=> !drv_en);

    // R13: reset level clears drive and soft-start
    assert_reset_lo_R13: assert property (@(posedge clk) disable iff (rst)
        vcc_reset_lo |=> (!drv_en && !ss_active));

endmodule

bind cvt_supervisor cvt_supervisor_chk #(
    .SS_TICKS   (SS_TICKS),
    .FAULT_TICKS(FAULT_TICKS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vcc_reset_lo(vcc_reset_lo),
    .cs_stop     (cs_stop),
    .ilim_hit    (ilim_hit),
    .maxduty_end (maxduty_end),
    .skip_out    (skip_out),
    .drv_en      (drv_en),
    .ss_active   (ss_active),
    .cur_state   (cur_state),
    .ft_cnt      (ft_cnt)
);

// File: tb/cvt_supervisor_bench.sv
`timescale 1ns/1ps
module cvt_supervisor_bench;

    localparam int unsigned SS    = 20;
    localparam int unsigned FLT   = 40;
    localparam int unsigned BLANK = 8;
    localparam int unsigned LHI   = 12;
    localparam int unsigned LLO   = 30;
    localparam int unsigned AR    = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_autorec = 1'b0;
    logic vcc_on = 1'b0, vcc_off = 1'b0, vcc_reset_lo = 1'b0, vcc_ovp = 1'b0;
    logic tsd = 1'b0, ilim_hit = 1'b0, cs_stop = 1'b0, maxduty_end = 1'b0;
    logic skip_in = 1'b0, skip_out = 1'b0, latch_hi = 1'b0, latch_lo = 1'b0;
    logic drv_en, ss_active, latch_dbl;

    always #4 clk = ~clk;

    cvt_supervisor #(
        .SS_TICKS(SS), .FAULT_TICKS(FLT), .BLANK_TICKS(BLANK),
        .LHI_TICKS(LHI), .LLO_TICKS(LLO), .AR_TICKS(AR)
    ) u_cvt_supervisor (
        .clk(clk), .rst(rst), .cfg_autorec(cfg_autorec),
        .vcc_on(vcc_on), .vcc_off(vcc_off), .vcc_reset_lo(vcc_reset_lo),
        .vcc_ovp(vcc_ovp), .tsd(tsd), .ilim_hit(ilim_hit), .cs_stop(cs_stop),
        .maxduty_end(maxduty_end), .skip_in(skip_in), .skip_out(skip_out),
        .latch_hi(latch_hi), .latch_lo(latch_lo),
        .drv_en(drv_en), .ss_active(ss_active), .latch_dbl(latch_dbl)
    );

    typedef struct {
        string req;
        logic  drv;
        logic  ss;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    // Monitor: compare queued expectations half a cycle after each edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (drv_en !== e.drv || ss_active !== e.ss || latch_dbl !== e.ss) begin
                n_err++;
                $display("FAIL %s: drv_en=%b ss_active=%b latch_dbl=%b expected %b %b %b",
                         e.req, drv_en, ss_active, latch_dbl, e.drv, e.ss, e.ss);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(input string req, input logic d, input logic s);
        exp_t e;
        e.req = req;
        e.drv = d;
        e.ss  = s;
        sb_q.push_back(e);
    endtask

    task automatic power_up();
        vcc_on = 1'b1;
        step(1);
        expect_out("R2 soft-start entry", 1'b1, 1'b1);
        step(SS - 1);
        expect_out("R2 soft-start last cycle", 1'b1, 1'b1);
        step(1);
        expect_out("R2 regulation", 1'b1, 1'b0);
    endtask

    task automatic supply_reset();
        vcc_on = 1'b0;
        vcc_reset_lo = 1'b1;
        step(1);
        expect_out("R13 reset level", 1'b0, 1'b0);
        vcc_reset_lo = 1'b0;
        step(1);
    endtask

    initial begin
        // R1
        step(3);
        expect_out("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        step(3);
        expect_out("R1 idle without turn-on", 1'b0, 1'b0);
        power_up();

        // R3 then R7
        ilim_hit = 1'b1;
        step(FLT);
        expect_out("R3 overload window edge", 1'b1, 1'b0);
        step(1);
        expect_out("R3 overload trip", 1'b0, 1'b0);
        ilim_hit = 1'b0;
        step(AR + 5);
        expect_out("R7 latched with turn-on high", 1'b0, 1'b0);
        tsd = 1'b1; step(2); tsd = 1'b0;
        vcc_off = 1'b1; step(BLANK + 3); vcc_off = 1'b0;
        step(2);
        expect_out("R7 latched after tsd and turn-off", 1'b0, 1'b0);
        supply_reset();
        power_up();

        // R4
        ilim_hit = 1'b1; step(FLT - 1);
        ilim_hit = 1'b0; step(1);
        ilim_hit = 1'b1; step(FLT);
        expect_out("R4 count restarted", 1'b1, 1'b0);
        step(1);
        expect_out("R4 trip after full window", 1'b0, 1'b0);
        ilim_hit = 1'b0;
        supply_reset();
        power_up();

        // R5 exemption at zero
        ilim_hit = 1'b1; maxduty_end = 1'b1; step(6);
        maxduty_end = 1'b0; step(FLT);
        expect_out("R5 duty-limited cycles not counted", 1'b1, 1'b0);
        step(1);
        expect_out("R5 trip", 1'b0, 1'b0);
        ilim_hit = 1'b0;
        supply_reset();
        power_up();

        // R5 running count continues
        ilim_hit = 1'b1; step(1);
        maxduty_end = 1'b1; step(FLT - 1);
        expect_out("R5 running count edge", 1'b1, 1'b0);
        step(1);
        expect_out("R5 running count not paused", 1'b0, 1'b0);
        ilim_hit = 1'b0; maxduty_end = 1'b0;
        supply_reset();
        power_up();

        // R6
        cs_stop = 1'b1; step(1);
        expect_out("R6 immediate stop", 1'b0, 1'b0);
        cs_stop = 1'b0;
        supply_reset();
        power_up();

        // R11
        skip_in = 1'b1; step(1);
        expect_out("R11 skip entry", 1'b0, 1'b0);
        skip_in = 1'b0; step(4);
        expect_out("R11 skip held", 1'b0, 1'b0);
        skip_out = 1'b1; step(1);
        expect_out("R11 skip exit", 1'b1, 1'b0);
        skip_out = 1'b0;

        // R10 short then exact window
        latch_lo = 1'b1; step(LLO - 1);
        latch_lo = 1'b0; step(3);
        expect_out("R10 short low pulse ignored", 1'b1, 1'b0);
        supply_reset();

        // R10 held through soft-start
        latch_lo = 1'b1;
        power_up();
        step(LLO);
        expect_out("R10 not counted in soft-start", 1'b1, 1'b0);
        step(1);
        expect_out("R10 low latch trip", 1'b0, 1'b0);
        latch_lo = 1'b0;
        supply_reset();

        // R9 high latch honoured in soft-start
        latch_hi = 1'b1; vcc_on = 1'b1;
        step(1);
        expect_out("R9 soft-start with high latch", 1'b1, 1'b1);
        step(LHI);
        expect_out("R9 high latch window edge", 1'b1, 1'b1);
        step(1);
        expect_out("R9 high latch trip", 1'b0, 1'b0);
        latch_hi = 1'b0;
        supply_reset();
        power_up();

        // R9 overvoltage
        vcc_ovp = 1'b1; step(BLANK - 1);
        vcc_ovp = 1'b0; step(2);
        expect_out("R9 short overvoltage ignored", 1'b1, 1'b0);
        vcc_ovp = 1'b1; step(BLANK);
        expect_out("R9 overvoltage window edge", 1'b1, 1'b0);
        step(1);
        expect_out("R9 overvoltage trip", 1'b0, 1'b0);
        vcc_ovp = 1'b0; step(3);
        expect_out("R9 overvoltage latched", 1'b0, 1'b0);
        supply_reset();
        power_up();

        // R12 turn-off blanking, thermal stop and timer clear
        vcc_off = 1'b1; step(BLANK - 1);
        vcc_off = 1'b0; step(2);
        expect_out("R12 short turn-off ignored", 1'b1, 1'b0);
        ilim_hit = 1'b1; step(FLT - 3);
        ilim_hit = 1'b0;
        tsd = 1'b1; step(1);
        expect_out("R12 thermal stop", 1'b0, 1'b0);
        step(2);
        expect_out("R12 no restart while hot", 1'b0, 1'b0);
        tsd = 1'b0; step(1);
        expect_out("R12 restart after thermal", 1'b1, 1'b1);
        step(SS);
        expect_out("R12 regulation after restart", 1'b1, 1'b0);
        ilim_hit = 1'b1; step(FLT);
        expect_out("R12 overload count cleared", 1'b1, 1'b0);
        step(1);
        expect_out("R12 trip after full window", 1'b0, 1'b0);
        ilim_hit = 1'b0;
        supply_reset();
        power_up();
        vcc_on = 1'b0;
        vcc_off = 1'b1; step(BLANK);
        expect_out("R12 turn-off window edge", 1'b1, 1'b0);
        step(1);
        expect_out("R12 turn-off stop", 1'b0, 1'b0);
        vcc_off = 1'b0; vcc_on = 1'b1; step(1);
        expect_out("R12 not latched", 1'b1, 1'b1);

        // R8 autorecovery option
        vcc_on = 1'b0;
        rst = 1'b1; cfg_autorec = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        power_up();
        cs_stop = 1'b1; step(1);
        expect_out("R8 fault pause entry", 1'b0, 1'b0);
        cs_stop = 1'b0; step(AR - 1);
        expect_out("R8 pause last cycle", 1'b0, 1'b0);
        step(1);
        expect_out("R8 idle after pause", 1'b0, 1'b0);
        step(1);
        expect_out("R8 automatic restart", 1'b1, 1'b1);
        step(SS);
        ilim_hit = 1'b1; step(FLT + 1);
        expect_out("R8 overload pause", 1'b0, 1'b0);
        ilim_hit = 1'b0;

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule